// File: doc/BRIEF.md
# Queued SPI Master Engine

This block is an SPI master that runs a list of transfers held in a small on-chip queue, without software taking part in each transfer. Software writes the transmit entries, where each entry holds a data word and a chip-select index. It also programs the clock, the word length, the delays and the queue bounds. Setting the run bit then starts the engine. For each entry, the engine asserts that entry's chip select and waits a lead delay. It then shifts the word out MSB first while sampling MISO, waits a trail delay, and moves on to the next entry.

Each received word is written to a receive memory at the index of its entry. After the end entry, the engine does one of two things. With wrap enabled, it jumps to a programmed wrap index and keeps running. With wrap disabled, it stops and raises a done flag. A halt bit makes the engine stop cleanly after the entry in progress. A loopback option feeds the internal MOSI value back into the receiver for self-test. An open-drain option turns the MOSI pin into a drive-low-or-release output.

Register writes use a single write strobe with a 6-bit address:

| Address | Contents |
|---|---|
| 0 | baud [7:0], cpol [8], cpha [9], bits [14:10], open-drain [15], loopback [16] |
| 1 | lead [7:0], trail [15:8] |
| 2 | start [3:0], end [7:4], wrapTo [11:8], wrapEn [12] |
| 3 | run [0], halt [1] |
| 32+i | queue entry i: data [15:0], chip-select index [17:16] |

Top module: `spiq_top`

## Requirements
- R1: After reset, csN is all ones, sck is 0, and busy, done and halted are all 0. No chip select is asserted while the run bit is 0. Once run is set with a nonzero baud value, the engine starts at the start index. Only the chip select named by that entry is driven low, and at most one csN bit is ever low.
- R2: When an entry begins, its chip select goes low. sck then stays at cpol, and MOSI shows the word's MSB, for lead+1 clock cycles.
- R3: An entry shifts N bits, MSB first. The transfer is made of 2N half periods, and each half period lasts baud cycles. During half period h, sck equals cpol XOR cpha XOR (h mod 2), and MOSI carries bit N-1-floor(h/2) of the word.
- R4: The word length N is the bits field clamped to the range 8 to 16. Field values below 8 give 8, and values above 16 give 16.
- R5: After the last half period, the chip select stays low for trail+1 cycles, with sck at cpol and MOSI low. The next entry follows in the very next cycle, and the chip select does not change within an entry.
- R6: With wrapEn=0, the engine stops after the end entry. At that point all csN bits are high, busy is 0, done is 1, and lastIdx equals the end index. From the start index, the pointer advances by one per entry, modulo the queue depth.
- R7: With wrapEn=1, the entry after the end entry is the wrapTo entry, and running continues.
- R8: If halt is 1 when an entry finishes its trail delay, the engine stops after that entry. It then sets halted to 1, leaves done at 0, and sets lastIdx to that entry's index.
- R9: While the baud value is 0, the engine stays idle even with run set.
- R10: MISO is sampled on the last cycle of each half period where h mod 2 equals cpha. The N sampled bits are stored, MSB first, in the receive memory at the entry's index, with all bits above N cleared.
- R11: With loopback set, the receiver takes the internal MOSI value instead of the MISO pin. The stored word then equals the low N bits of the transmitted word.
- R12: With open-drain set, the mosi output is always 0 and mosiOe is high only while an entry is active and the MOSI bit is 0. Without open-drain, mosiOe is always 1.
- R13: A write to the control register clears done and halted. Writing run=1 again after the engine has stopped restarts it from the start index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register or queue-entry write strobe |
| wrAddr | input | 6 | Write address |
| wrData | input | 24 | Write data |
| rdIdx | input | 4 | Receive memory read index |
| rdData | output | 16 | Received word at rdIdx |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out value |
| mosiOe | output | 1 | MOSI drive enable |
| csN | output | 4 | Active-low chip selects |
| busy | output | 1 | Engine is running an entry |
| done | output | 1 | End of queue reached without wrap |
| halted | output | 1 | Engine stopped by halt |
| lastIdx | output | 4 | Index of the last completed entry |

## Verification
The assertions assume that the configuration registers and the queue contents are not rewritten while an entry is active. Under that assumption, the chip select is stable within an entry, and the wrap target and the word length sampled at the end of a transfer are the programmed ones. The stimulus follows this rule: it writes configuration and entries only while busy is low, and while the engine runs it writes only the control register (to request a halt). The reference model rebuilds every cycle of sck, the chip selects and the MOSI line from the requirements alone, and compares them on every clock. The runs cover all four cpol/cpha pairs, word lengths 8, 12 and 16 (including both clamp directions), queue stop, wrap, halt after the first entry and halt partway through a wrapped run, loopback, open-drain and a zero baud value.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int QDEPTH   = 16;
  localparam int QIDX_W   = $clog2(QDEPTH);
  localparam int WORD_W   = 16;
  localparam int NCS      = 4;
  localparam int CSSEL_W  = $clog2(NCS);
  localparam int CNT_W    = 8;
  localparam int BITS_W   = $clog2(WORD_W) + 1;
  localparam int HALF_W   = $clog2(2 * WORD_W);
  localparam int MIN_BITS = 8;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} engState_t;

  typedef struct packed {
    logic [QIDX_W-1:0] ptr;
    logic [HALF_W-2:0] bitIdx;
    logic              lead;
    logic              shift;
    logic              capture;
    logic              store;
    logic [BITS_W-1:0] nBits;
    logic              wired;
    logic              loop;
    logic              active;
  } dpStrobe_t;
endpackage

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CSSEL_W-1:0]  entrySel,
  output dpStrobe_t           stb,
  output logic                sck,
  output logic [NCS-1:0]      csN,
  output logic                busy,
  output logic                done,
  output logic                halted,
  output logic [QIDX_W-1:0]   lastIdx
);
  logic [CNT_W-1:0]  baud, leadDly, trailDly, cnt;
  logic              cpol, cpha, wired, loopEn, wrapEn, enReg, haltReg;
  logic [BITS_W-1:0] bitsField, nBits;
  logic [QIDX_W-1:0] newPtr, endPtr, wrapTo, ptr;
  logic [HALF_W-1:0] half;
  logic [HALF_W:0]   halfLast;
  engState_t         state;
  logic              regWr, halfEnd, trailEnd;

  assign regWr    = wrEn && !wrAddr[ADDR_W-1];
  assign halfEnd  = (cnt == baud - 1'b1);
  assign trailEnd = (state == ST_TRAIL) && (cnt == trailDly);
  assign halfLast = (HALF_W+1)'({nBits, 1'b0}) - 1'b1;

  always_comb begin
    if (bitsField < BITS_W'(MIN_BITS))    nBits = BITS_W'(MIN_BITS);
    else if (bitsField > BITS_W'(WORD_W)) nBits = BITS_W'(WORD_W);
    else                                  nBits = bitsField;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baud <= '0; leadDly <= '0; trailDly <= '0; cnt <= '0;
      cpol <= 1'b0; cpha <= 1'b0; wired <= 1'b0; loopEn <= 1'b0;
      wrapEn <= 1'b0; enReg <= 1'b0; haltReg <= 1'b0;
      bitsField <= BITS_W'(MIN_BITS);
      newPtr <= '0; endPtr <= '0; wrapTo <= '0; ptr <= '0;
      half <= '0; state <= ST_IDLE;
      done <= 1'b0; halted <= 1'b0; lastIdx <= '0;
    end else begin
      if (regWr) begin
        case (wrAddr[1:0])
          2'd0: begin
            baud <= wrData[7:0]; cpol <= wrData[8]; cpha <= wrData[9];
            bitsField <= wrData[14:10]; wired <= wrData[15]; loopEn <= wrData[16];
          end
          2'd1: begin leadDly <= wrData[7:0]; trailDly <= wrData[15:8]; end
          2'd2: begin
            newPtr <= wrData[3:0]; endPtr <= wrData[7:4];
            wrapTo <= wrData[11:8]; wrapEn <= wrData[12];
          end
          default: begin
            enReg <= wrData[0]; haltReg <= wrData[1];
            done <= 1'b0; halted <= 1'b0;
          end
        endcase
      end
      case (state)
        ST_IDLE: if (enReg && baud != '0 && !done && !halted) begin
          ptr <= newPtr; cnt <= '0; state <= ST_LEAD;
        end
        ST_LEAD: if (cnt == leadDly) begin
          cnt <= '0; half <= '0; state <= ST_SHIFT;
        end else cnt <= cnt + 1'b1;
        ST_SHIFT: if (halfEnd) begin
          cnt <= '0;
          if ({1'b0, half} == halfLast) state <= ST_TRAIL;
          else half <= half + 1'b1;
        end else cnt <= cnt + 1'b1;
        default: if (trailEnd) begin
          cnt <= '0;
          lastIdx <= ptr;
          if (haltReg || !enReg) begin
            state <= ST_IDLE; halted <= haltReg;
          end else if (ptr == endPtr) begin
            if (wrapEn) begin ptr <= wrapTo; state <= ST_LEAD; end
            else begin state <= ST_IDLE; done <= 1'b1; end
          end else begin
            ptr <= ptr + 1'b1; state <= ST_LEAD;
          end
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign sck  = (state == ST_SHIFT) ? (cpol ^ cpha ^ half[0]) : cpol;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign csN[i] = !(busy && entrySel == CSSEL_W'(i));
  end

  always_comb begin
    stb.ptr     = ptr;
    stb.bitIdx  = half[HALF_W-1:1];
    stb.lead    = (state == ST_LEAD);
    stb.shift   = (state == ST_SHIFT);
    stb.capture = (state == ST_SHIFT) && halfEnd && (half[0] == cpha);
    stb.store   = (state == ST_TRAIL) && (cnt == '0);
    stb.nBits   = nBits;
    stb.wired   = wired;
    stb.loop    = loopEn;
    stb.active  = busy;
  end

  assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  assert_baud_zero_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && baud == '0 && !regWr) |=> (state == ST_IDLE));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_wrap_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    (trailEnd && !haltReg && enReg && ptr == endPtr && wrapEn && !regWr)
      |=> (ptr == $past(wrapTo) && state == ST_LEAD));
  assert_cs_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !(wrEn && wrAddr[ADDR_W-1])) |=> $stable(csN) || state == ST_TRAIL);
endmodule

// File: rtl/spiq_dp.sv
module spiq_dp
  import spiq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  dpStrobe_t          stb,
  input  logic               miso,
  input  logic [QIDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0]  rdData,
  output logic [CSSEL_W-1:0] entrySel,
  output logic               mosi,
  output logic               mosiOe
);
  localparam int POS_W = $clog2(WORD_W);

  logic [WORD_W+CSSEL_W-1:0] txMem [QDEPTH];
  logic [WORD_W-1:0]         rxMem [QDEPTH];
  logic [WORD_W-1:0]         rxSh, txWord, rxMask;
  logic [BITS_W-1:0]         bitPos;
  logic                      mosiVal, inBit;

  assign txWord   = txMem[stb.ptr][WORD_W-1:0];
  assign entrySel = txMem[stb.ptr][WORD_W +: CSSEL_W];
  assign bitPos   = stb.shift ? (stb.nBits - 1'b1 - BITS_W'(stb.bitIdx)) : (stb.nBits - 1'b1);
  assign mosiVal  = (stb.lead || stb.shift) && txWord[bitPos[POS_W-1:0]];
  assign inBit    = stb.loop ? mosiVal : miso;
  assign rxMask   = {WORD_W{1'b1}} >> (BITS_W'(WORD_W) - stb.nBits);
  assign rdData   = rxMem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) begin
        txMem[i] <= '0;
        rxMem[i] <= '0;
      end
      rxSh <= '0;
    end else begin
      if (wrEn && wrAddr[ADDR_W-1])
        txMem[wrAddr[QIDX_W-1:0]] <= wrData[WORD_W+CSSEL_W-1:0];
      if (stb.capture) rxSh <= {rxSh[WORD_W-2:0], inBit};
      if (stb.store)   rxMem[stb.ptr] <= rxSh & rxMask;
    end
  end

  always_comb begin
    if (stb.wired) begin
      mosi   = 1'b0;
      mosiOe = stb.active && !mosiVal;
    end else begin
      mosi   = mosiVal;
      mosiOe = 1'b1;
    end
  end

  assert_rx_upper_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.store |=> ((rxMem[$past(stb.ptr)] >> $past(stb.nBits)) == '0));
  assert_wired_no_high_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.wired |-> !mosi);
endmodule

// File: rtl/spiq_top.sv
module spiq_top
  import spiq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [QIDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0]  rdData,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               mosiOe,
  output logic [NCS-1:0]     csN,
  output logic               busy,
  output logic               done,
  output logic               halted,
  output logic [QIDX_W-1:0]  lastIdx
);
  dpStrobe_t          stb;
  logic [CSSEL_W-1:0] entrySel;

  spiq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .entrySel(entrySel), .stb(stb), .sck(sck), .csN(csN), .busy(busy),
    .done(done), .halted(halted), .lastIdx(lastIdx)
  );

  spiq_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(stb), .miso(miso), .rdIdx(rdIdx), .rdData(rdData),
    .entrySel(entrySel), .mosi(mosi), .mosiOe(mosiOe)
  );
endmodule

// File: tb/sim_spiq_top.sv
module sim_spiq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [3:0]  rdIdx = '0;
  logic [15:0] rdData;
  logic        miso, sck, mosi, mosiOe, busy, done, halted, line;
  logic [3:0]  csN, lastIdx;

  spiq_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .miso(miso), .sck(sck), .mosi(mosi),
    .mosiOe(mosiOe), .csN(csN), .busy(busy), .done(done), .halted(halted),
    .lastIdx(lastIdx)
  );

  always #4 clk = ~clk;

  assign line = mosiOe ? mosi : 1'b1;
  assign miso = ~line;

  int vecs = 0, errs = 0;
  bit finished = 0;
  int baud, lead, trail, nb;
  bit cpol, cpha, wired, loopb, clearPending;
  logic [15:0] txD [16];
  int          txS [16];
  logic [15:0] expRx [16];
  bit          rxValid [16];

  task automatic check(bit ok, string req, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkCycle(int sel, bit sckE, bit lineE, string req);
    logic [3:0] expCs;
    @(negedge clk);
    expCs = (sel < 0) ? 4'hF : ~(4'b0001 << sel);
    check(csN == expCs, req, "csN", csN, expCs);
    check(sck == sckE, req, "sck", sck, sckE);
    check(line == lineE, wired ? "R12" : req, "mosi line", line, lineE);
    if (!wired) check(mosiOe == 1'b1, "R12", "mosiOe push-pull", mosiOe, 1);
    if (clearPending) begin wrEn = 1'b0; clearPending = 0; end
  endtask

  task automatic regWrite(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 6'(addr); wrData = 24'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCfg(int b, bit pol, bit pha, int bitsF, bit wo, bit lp, int ld, int tr);
    baud = b; cpol = pol; cpha = pha; wired = wo; loopb = lp; lead = ld; trail = tr;
    nb = (bitsF < 8) ? 8 : (bitsF > 16) ? 16 : bitsF;  // R4 clamp
    regWrite(0, (int'(lp) << 16) | (int'(wo) << 15) | (bitsF << 10) |
                (int'(pha) << 9) | (int'(pol) << 8) | b);
    regWrite(1, (tr << 8) | ld);
  endtask

  task automatic runEntry(int idx, bit doHalt);
    int s;
    logic [15:0] w, mask;
    s = txS[idx]; w = txD[idx];
    for (int c = 0; c <= lead; c++) chkCycle(s, cpol, w[nb-1], "R2");
    for (int h = 0; h < 2 * nb; h++)
      for (int c = 0; c < baud; c++) begin
        chkCycle(s, cpol ^ cpha ^ h[0], w[nb-1-h/2], "R3");
        if (doHalt && h == 0 && c == 0) begin
          wrEn = 1'b1; wrAddr = 6'd3; wrData = 24'd3; clearPending = 1;
        end
      end
    for (int c = 0; c <= trail; c++) chkCycle(s, cpol, 1'b0, "R5");
    mask = 16'((32'h1 << nb) - 1);
    expRx[idx] = loopb ? (w & mask) : (~w & mask);
    rxValid[idx] = 1;
  endtask

  task automatic runQueue(int first, int last, int wto, bit wrap, int haltAt);
    int ptr, n;
    bit stoppedHalt;
    for (int i = 0; i < 16; i++) rxValid[i] = 0;
    regWrite(2, (int'(wrap) << 12) | (wto << 8) | (last << 4) | first);
    regWrite(3, 1);
    check(done == 1'b0 && halted == 1'b0, "R13", "flags cleared by control write",
          {done, halted}, 0);
    ptr = first; n = 0; stoppedHalt = 0;
    forever begin
      n++;
      runEntry(ptr, n == haltAt);
      if (n == haltAt) begin stoppedHalt = 1; break; end
      if (ptr == last) begin
        if (wrap) ptr = wto;  // R7
        else break;
      end else ptr = (ptr + 1) % 16;
    end
    chkCycle(-1, cpol, wired, stoppedHalt ? "R8" : "R6");
    chkCycle(-1, cpol, wired, stoppedHalt ? "R8" : "R6");
    check(busy == 1'b0, stoppedHalt ? "R8" : "R6", "busy", busy, 0);
    check(done == !stoppedHalt, stoppedHalt ? "R8" : "R6", "done", done, !stoppedHalt);
    check(halted == stoppedHalt, "R8", "halted", halted, stoppedHalt);
    check(lastIdx == 4'(ptr), stoppedHalt ? "R8" : "R6", "lastIdx", lastIdx, ptr);
    for (int i = 0; i < 16; i++)
      if (rxValid[i]) begin
        rdIdx = 4'(i);
        #1;
        check(rdData == expRx[i], loopb ? "R11" : "R10", "rx word", rdData, expRx[i]);
      end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      txD[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
      txS[i] = i % 4;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(csN == 4'hF, "R1", "reset csN", csN, 4'hF);
    check(sck == 1'b0, "R1", "reset sck", sck, 0);
    check({busy, done, halted} == 3'b000, "R1", "reset flags", {busy, done, halted}, 0);
    for (int i = 0; i < 16; i++) regWrite(32 + i, (txS[i] << 16) | int'(txD[i]));

    // T1: mode 0, 8 bits, stop at end; R1 idle until run set
    setCfg(1, 0, 0, 8, 0, 0, 1, 2);
    for (int c = 0; c < 10; c++) chkCycle(-1, 1'b0, 1'b0, "R1");
    check(busy == 1'b0, "R1", "idle without run", busy, 0);
    runQueue(1, 3, 0, 0, 0);
    // R13 restart from start index after done
    runQueue(1, 3, 0, 0, 0);

    // T2: mode 3, 12 bits, loopback, wrap 2,3 -> 0, halt in the 5th entry (R7, R8, R11)
    setCfg(2, 1, 1, 12, 0, 1, 0, 0);
    runQueue(2, 3, 0, 1, 5);

    // T3: mode 1, bits field 20 clamps to 16 (R4), open-drain (R12)
    setCfg(3, 0, 1, 20, 1, 0, 3, 1);
    runQueue(5, 5, 0, 0, 0);

    // T4: mode 2, bits field 3 clamps to 8 (R4), loopback, halt after first entry (R8)
    setCfg(1, 1, 0, 3, 0, 1, 2, 0);
    runQueue(0, 4, 0, 0, 1);

    // T5: baud zero keeps the engine idle (R9)
    regWrite(3, 0);
    setCfg(0, 0, 0, 8, 0, 0, 0, 0);
    regWrite(3, 1);
    for (int c = 0; c < 20; c++) chkCycle(-1, 1'b0, 1'b0, "R9");
    check(busy == 1'b0 && done == 1'b0, "R9", "no activity at baud 0", {busy, done}, 0);
    regWrite(3, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule